// File: doc/BRIEF.md
# LED Fault Supervisor and Latch-off Controller

This block is the digital protection supervisor of a two-channel LED backlight driver that feeds its LED strings from a DC/DC converter. Analog comparators reach it as asynchronous flags: supply undervoltage, overtemperature, converter overvoltage and overcurrent. For each channel there is an LED-pin-low flag and an LED-pin-high flag. Two shared flags report the feedback level: one is set when the feedback is above the open-detect level, the other when it is below the short-detect level. The block also takes the global enable, the PWM dimming input, a channel-select input and a single-cycle tick at the converter switching frequency.

From these inputs the block drives the per-channel current-driver enables, a run request for the converter and a soft-start discharge request. It also drives two active-low fault flags: one for system-level faults and one for LED faults. An open LED string latches its own channel off at once. A shorted LED, or a channel pin pulled to ground, must persist for a programmable number of switching ticks before anything latches. The default is 32770 ticks, about 100 ms at 300 kHz. A short latches only its own channel. A ground short shuts down the whole output stage. All latches clear when enable drops, or when undervoltage or overtemperature is present.

Top module: `led_fault_supervisor`

## Requirements
- R1: After reset with enable low, every driver enable, the converter run request and the discharge request are 0, and both fault flags are 1 (inactive).
- R2: Channel i's driver enable is 1 only when the PWM input is 1 and the channel is selected, with no latch and no system shutdown. Channel-select 0 selects both channels; channel-select 1 selects channel 0 only.
- R3: While overvoltage or overcurrent is present, the discharge request is 1 and the converter run request is 0, and neither fault latches. Overvoltage also pulls the system fault flag low; overcurrent does not.
- R4: An LED-pin-low flag on any selected, unlatched channel makes the ground-short counter advance once per tick. After exactly TERM_COUNT ticks the ground-short latch sets. The latch turns off all drivers and the run request and pulls the system fault flag low.
- R5: If the ground-short condition drops before the terminal count, the ground-short counter returns to zero, so a full TERM_COUNT ticks are needed again.
- R6: When a selected channel's LED-pin-low flag and the open-level flag are both 1, that channel's open latch sets without waiting for any tick. Only that channel turns off, and the LED fault flag goes low. The latch stays set after the condition goes away.
- R7: When a selected channel's LED-pin-high flag and the below-short-level flag are both 1 while PWM is 1, that channel's short counter advances once per tick. After TERM_COUNT ticks the short latch sets, turns only that channel off and pulls the LED fault flag low.
- R8: While PWM is 0, a channel's short counter neither advances nor resets. Counting resumes from the held value when PWM returns to 1.
- R9: If the short condition drops while PWM is 1, that channel's short counter returns to zero.
- R10: Undervoltage or overtemperature turns off all drivers and the run request and pulls the system fault flag low. Enable low, undervoltage or overtemperature clears every open, short and ground-short latch.
- R11: A channel that channel-select leaves unselected is excluded from open, short and ground-short detection, and its counters stay at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_sw | input | 1 | One-cycle pulse per converter switching period |
| en_a | input | 1 | Global enable (asynchronous) |
| pwm_a | input | 1 | PWM dimming input (asynchronous) |
| chsel_a | input | 1 | Channel select: 0 both channels, 1 channel 0 only |
| uv_a | input | 1 | Supply undervoltage flag |
| ot_a | input | 1 | Overtemperature flag |
| ov_a | input | 1 | Converter overvoltage flag |
| oc_a | input | 1 | Converter overcurrent flag |
| led_lo_a | input | NUM_CH | Per-channel LED pin below low threshold |
| led_hi_a | input | NUM_CH | Per-channel LED pin above high threshold |
| ovp_open_a | input | 1 | Feedback above open-detect level |
| ovp_short_a | input | 1 | Feedback below short-detect level |
| drv_en | output | NUM_CH | Per-channel current-driver enable |
| conv_run | output | 1 | Converter switching allowed |
| ss_discharge | output | 1 | Soft-start discharge request |
| sys_fault_n | output | 1 | Active-low system fault flag |
| led_fault_n | output | 1 | Active-low LED fault flag |

## Verification
The bench places the timed latches at the exact terminal tick. It checks that nothing latches one tick early and that the latch sets on the next tick, which catches an off-by-one counter. It drops a short or ground condition partway through a count and confirms that a full count is needed again; a counter that only pauses would latch too early. It holds PWM low in the middle of a short count and confirms that the count is neither lost nor advanced. It also confirms that an unselected channel never latches, and that undervoltage, overtemperature and enable-low each wipe the latches. A design that decoded channel-select the wrong way round, or cleared on the wrong inputs, would leave a channel dark or a fault flag stuck.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

   // System-level comparator flags after synchronization
   typedef struct packed {
      logic uv;
      logic ot;
      logic ov;
      logic oc;
   } sys_flags_t;

   // Width needed to hold a count up to limit
   function automatic int cnt_width(input int limit);
      int w;
      w = 1;
      while ((1 << w) <= limit) w++;
      return w;
   endfunction

   // Shutdown of the whole output stage (converter and drivers)
   function automatic logic stage_kill(input sys_flags_t f, input logic gnd_latched);
      return f.uv | f.ot | gnd_latched;
   endfunction

endpackage

// File: rtl/lfs_sync.sv
module lfs_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   initial begin : g_param_chk
      assert (STAGES >= 2) else $error("lfs_sync: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $error("lfs_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/lfs_timer.sv
module lfs_timer #(
   parameter int TERM_COUNT = 32770,
   localparam int CW = lfs_pkg::cnt_width(TERM_COUNT)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,     // synchronous zero (latch clear)
   input  logic arm,     // condition present; low returns count to zero
   input  logic hold,    // freeze count, no advance, no reset
   input  logic tick,    // switching-period enable
   output logic expire   // one-cycle pulse on the terminal tick
);

   localparam logic [CW-1:0] LAST = CW'(TERM_COUNT - 1);

   initial begin : g_param_chk
      assert (TERM_COUNT >= 2) else $error("lfs_timer: TERM_COUNT must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic          adv;

   assign adv    = arm & ~hold & ~clr & tick;
   assign expire = adv & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr || !arm)  cnt <= '0;
      else if (expire)       cnt <= '0;
      else if (adv)          cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/lfs_channel.sv
module lfs_channel #(
   parameter int TERM_COUNT = 32770
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   input  logic selected,
   input  logic pwm,
   input  logic led_lo,
   input  logic led_hi,
   input  logic ovp_open,
   input  logic ovp_short,
   output logic open_lat,
   output logic short_lat,
   output logic ok,
   output logic gnd_cond
);

   logic short_cond;
   logic short_exp;

   assign ok         = selected & ~open_lat & ~short_lat;
   assign gnd_cond   = ok & led_lo;
   assign short_cond = led_hi & ovp_short;

   // Open: immediate, per channel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         open_lat <= 1'b0;
      else if (clr)                       open_lat <= 1'b0;
      else if (ok && led_lo && ovp_open)  open_lat <= 1'b1;
   end

   // Short: counted only while PWM is high; frozen while PWM is low
   lfs_timer #(.TERM_COUNT(TERM_COUNT)) u_short_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .arm    (ok & (~pwm | short_cond)),
      .hold   (~pwm),
      .tick   (tick),
      .expire (short_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          short_lat <= 1'b0;
      else if (clr)        short_lat <= 1'b0;
      else if (short_exp)  short_lat <= 1'b1;
   end

endmodule

// File: rtl/led_fault_supervisor.sv
module led_fault_supervisor #(
   parameter int NUM_CH      = 2,
   parameter int TERM_COUNT  = 32770,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_sw,
   input  logic              en_a,
   input  logic              pwm_a,
   input  logic              chsel_a,
   input  logic              uv_a,
   input  logic              ot_a,
   input  logic              ov_a,
   input  logic              oc_a,
   input  logic [NUM_CH-1:0] led_lo_a,
   input  logic [NUM_CH-1:0] led_hi_a,
   input  logic              ovp_open_a,
   input  logic              ovp_short_a,
   output logic [NUM_CH-1:0] drv_en,
   output logic              conv_run,
   output logic              ss_discharge,
   output logic              sys_fault_n,
   output logic              led_fault_n
);
   import lfs_pkg::*;

   localparam int NSC   = 9;
   localparam int NSYNC = NSC + 2 * NUM_CH;

   initial begin : g_param_chk
      assert (NUM_CH >= 1) else $error("led_fault_supervisor: NUM_CH must be positive");
   end

   // Synchronized inputs
   logic [NSYNC-1:0] raw_in, syn;
   logic             en_s, pwm_s, chsel_s, ovp_open_s, ovp_short_s;
   sys_flags_t       flg_s;
   logic [NUM_CH-1:0] led_lo_s, led_hi_s;

   assign raw_in = {en_a, pwm_a, chsel_a, uv_a, ot_a, ov_a, oc_a,
                    ovp_open_a, ovp_short_a, led_lo_a, led_hi_a};

   lfs_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_in),
      .q_sync  (syn)
   );

   assign {en_s, pwm_s, chsel_s, flg_s.uv, flg_s.ot, flg_s.ov, flg_s.oc,
           ovp_open_s, ovp_short_s, led_lo_s, led_hi_s} = syn;

   logic uv_s, ot_s, ov_s, oc_s, clr_s;
   assign uv_s  = flg_s.uv;
   assign ot_s  = flg_s.ot;
   assign ov_s  = flg_s.ov;
   assign oc_s  = flg_s.oc;
   assign clr_s = ~en_s | uv_s | ot_s;

   // Per-channel supervision
   logic [NUM_CH-1:0] sel, open_lat, short_lat, ch_ok, gnd_cond;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      if (i == 0) begin : g_primary
         assign sel[i] = en_s;
      end else begin : g_secondary
         assign sel[i] = en_s & ~chsel_s;
      end

      lfs_channel #(.TERM_COUNT(TERM_COUNT)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick_sw),
         .clr       (clr_s),
         .selected  (sel[i] & ~gnd_lat),
         .pwm       (pwm_s),
         .led_lo    (led_lo_s[i]),
         .led_hi    (led_hi_s[i]),
         .ovp_open  (ovp_open_s),
         .ovp_short (ovp_short_s),
         .open_lat  (open_lat[i]),
         .short_lat (short_lat[i]),
         .ok        (ch_ok[i]),
         .gnd_cond  (gnd_cond[i])
      );
   end

   // Ground-short supervision (whole circuit)
   logic gnd_lat;
   logic gnd_exp;

   lfs_timer #(.TERM_COUNT(TERM_COUNT)) u_gnd_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_s),
      .arm    (|gnd_cond),
      .hold   (1'b0),
      .tick   (tick_sw),
      .expire (gnd_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gnd_lat <= 1'b0;
      else if (clr_s)    gnd_lat <= 1'b0;
      else if (gnd_exp)  gnd_lat <= 1'b1;
   end

   // Outputs
   logic kill;
   assign kill = stage_kill(flg_s, gnd_lat);

   assign drv_en       = (kill || !pwm_s) ? '0 : ch_ok;
   assign ss_discharge = ov_s | oc_s;
   assign conv_run     = ~kill & ~ss_discharge & (|ch_ok);
   assign sys_fault_n  = ~(uv_s | ot_s | ov_s | gnd_lat);
   assign led_fault_n  = ~(|open_lat | |short_lat);

endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_sw,
   input logic              pwm_s,
   input logic              ov_s,
   input logic              oc_s,
   input logic              clr_s,
   input logic [NUM_CH-1:0] open_lat,
   input logic [NUM_CH-1:0] short_lat,
   input logic              gnd_lat,
   input logic [NUM_CH-1:0] drv_en,
   input logic              conv_run,
   input logic              sys_fault_n
);

   AST_PWM_LOW_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_s |-> (drv_en == '0)); // R2

   AST_OVOC_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_s || oc_s) |-> !conv_run); // R3

   AST_GND_KILLS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      gnd_lat |-> (drv_en == '0 && !conv_run && !sys_fault_n)); // R4

   AST_OPEN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s |=> ((open_lat & $past(open_lat)) == $past(open_lat))); // R6

   AST_LATCHED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en & (open_lat | short_lat)) == '0); // R7

   AST_SHORT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ((short_lat & ~$past(short_lat)) != '0) |-> $past(tick_sw)); // R7

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_s |=> (open_lat == '0 && short_lat == '0 && !gnd_lat)); // R10

endmodule

bind led_fault_supervisor lfs_checker #(.NUM_CH(NUM_CH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_sw     (tick_sw),
   .pwm_s       (pwm_s),
   .ov_s        (ov_s),
   .oc_s        (oc_s),
   .clr_s       (clr_s),
   .open_lat    (open_lat),
   .short_lat   (short_lat),
   .gnd_lat     (gnd_lat),
   .drv_en      (drv_en),
   .conv_run    (conv_run),
   .sys_fault_n (sys_fault_n)
);

// File: tb/tb_led_fault_supervisor.sv
module tb_led_fault_supervisor;

   localparam int CLK_PERIOD = 10;
   localparam int TERM       = 10;
   localparam int NCH        = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_sw = 1'b0;
   logic en_a = 1'b0, pwm_a = 1'b0, chsel_a = 1'b0;
   logic uv_a = 1'b0, ot_a = 1'b0, ov_a = 1'b0, oc_a = 1'b0;
   logic [NCH-1:0] led_lo_a = '0, led_hi_a = '0;
   logic ovp_open_a = 1'b0, ovp_short_a = 1'b0;
   logic [NCH-1:0] drv_en;
   logic conv_run, ss_discharge, sys_fault_n, led_fault_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   led_fault_supervisor #(.NUM_CH(NCH), .TERM_COUNT(TERM), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .tick_sw(tick_sw),
      .en_a(en_a), .pwm_a(pwm_a), .chsel_a(chsel_a),
      .uv_a(uv_a), .ot_a(ot_a), .ov_a(ov_a), .oc_a(oc_a),
      .led_lo_a(led_lo_a), .led_hi_a(led_hi_a),
      .ovp_open_a(ovp_open_a), .ovp_short_a(ovp_short_a),
      .drv_en(drv_en), .conv_run(conv_run), .ss_discharge(ss_discharge),
      .sys_fault_n(sys_fault_n), .led_fault_n(led_fault_n)
   );

   // Scoreboard: expected {drv_en[1], drv_en[0], conv_run, ss_discharge, sys_fault_n, led_fault_n}
   string          req_q[$];
   logic [5:0]     exp_q[$];

   initial begin : monitor
      forever begin
         logic [5:0] got;
         logic [5:0] exp_v;
         string      req;
         @(posedge clk);
         #(CLK_PERIOD/4);
         while (exp_q.size() > 0) begin
            exp_v = exp_q.pop_front();
            req   = req_q.pop_front();
            got   = {drv_en[1], drv_en[0], conv_run, ss_discharge, sys_fault_n, led_fault_n};
            checks++;
            if (got !== exp_v) begin
               errors++;
               $display("FAIL %s: got %b expected %b", req, got, exp_v);
            end
         end
      end
   end

   task automatic expect_out(input string req, input logic [5:0] e);
      req_q.push_back(req);
      exp_q.push_back(e);
      wait (exp_q.size() == 0);
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         tick_sw = 1'b1;
         @(negedge clk);
         tick_sw = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic clear_by_enable();
      en_a = 1'b0; settle();
      en_a = 1'b1; settle();
   endtask

   localparam logic [5:0] ALL_ON = 6'b11_1_0_1_1;

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): run did not complete, got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      expect_out("R1 reset state", 6'b00_0_0_1_1);

      // R2: gating and channel select
      en_a = 1'b1; pwm_a = 1'b1; settle();
      expect_out("R2 both channels on", ALL_ON);
      chsel_a = 1'b1; settle();
      expect_out("R2 select ch0 only", 6'b01_1_0_1_1);
      chsel_a = 1'b0; pwm_a = 1'b0; settle();
      expect_out("R2 pwm low darkens", 6'b00_1_0_1_1);
      pwm_a = 1'b1; settle();

      // R3: overvoltage / overcurrent, non-latching
      ov_a = 1'b1; settle();
      expect_out("R3 overvoltage", 6'b11_0_1_0_1);
      ov_a = 1'b0; settle();
      expect_out("R3 overvoltage released", ALL_ON);
      oc_a = 1'b1; settle();
      expect_out("R3 overcurrent", 6'b11_0_1_1_1);
      oc_a = 1'b0; settle();
      expect_out("R3 overcurrent released", ALL_ON);

      // R6: open on channel 1, immediate, sticky
      led_lo_a[1] = 1'b1; ovp_open_a = 1'b1; settle();
      expect_out("R6 open latches ch1", 6'b01_1_0_1_0);
      led_lo_a[1] = 1'b0; ovp_open_a = 1'b0; settle();
      expect_out("R6 open stays latched", 6'b01_1_0_1_0);
      en_a = 1'b0; settle();
      expect_out("R10 enable low outputs", 6'b00_0_0_1_1);
      en_a = 1'b1; settle();
      expect_out("R10 enable low cleared open", ALL_ON);

      // R4: ground short terminal count
      led_lo_a[0] = 1'b1; settle();
      ticks(TERM - 1);
      expect_out("R4 no latch one tick early", ALL_ON);
      ticks(1);
      expect_out("R4 ground latch at terminal", 6'b00_0_0_0_1);
      led_lo_a[0] = 1'b0; settle();
      expect_out("R4 ground latch sticky", 6'b00_0_0_0_1);
      uv_a = 1'b1; settle();
      expect_out("R10 undervoltage outputs", 6'b00_0_0_0_1);
      uv_a = 1'b0; settle();
      expect_out("R10 undervoltage cleared ground", ALL_ON);

      // R5: ground count resets on release
      led_lo_a[0] = 1'b1; settle();
      ticks(TERM - 1);
      led_lo_a[0] = 1'b0; settle();
      led_lo_a[0] = 1'b1; settle();
      ticks(TERM - 1);
      expect_out("R5 count restarted", ALL_ON);
      ticks(1);
      expect_out("R5 latch after full recount", 6'b00_0_0_0_1);
      led_lo_a[0] = 1'b0;
      ot_a = 1'b1; settle();
      expect_out("R10 overtemperature outputs", 6'b00_0_0_0_1);
      ot_a = 1'b0; settle();
      expect_out("R10 overtemperature cleared ground", ALL_ON);

      // R7 / R8: short on channel 0, PWM low freezes count
      led_hi_a[0] = 1'b1; ovp_short_a = 1'b1; settle();
      ticks(TERM - 1);
      expect_out("R7 no short latch one tick early", ALL_ON);
      pwm_a = 1'b0; settle();
      ticks(5);
      expect_out("R8 pwm low no advance", 6'b00_1_0_1_1);
      pwm_a = 1'b1; settle();
      ticks(1);
      expect_out("R8 count held across pwm low", 6'b10_1_0_1_0);
      led_hi_a[0] = 1'b0; ovp_short_a = 1'b0; settle();
      expect_out("R7 short latch sticky", 6'b10_1_0_1_0);
      clear_by_enable();
      expect_out("R10 enable clears short", ALL_ON);

      // R9: short condition dropping with PWM high resets count
      led_hi_a[0] = 1'b1; ovp_short_a = 1'b1; settle();
      ticks(TERM - 1);
      ovp_short_a = 1'b0; settle();
      ovp_short_a = 1'b1; settle();
      ticks(TERM - 1);
      expect_out("R9 short count restarted", ALL_ON);
      ticks(1);
      expect_out("R9 short latch after full recount", 6'b10_1_0_1_0);
      led_hi_a[0] = 1'b0; ovp_short_a = 1'b0;
      clear_by_enable();

      // R11: unselected channel excluded
      chsel_a = 1'b1; settle();
      led_lo_a[1] = 1'b1; ovp_open_a = 1'b1; settle();
      expect_out("R11 no open on unselected ch1", 6'b01_1_0_1_1);
      ovp_open_a = 1'b0; settle();
      ticks(TERM + 2);
      expect_out("R11 no ground count on unselected ch1", 6'b01_1_0_1_1);
      led_lo_a[1] = 1'b0; led_hi_a[1] = 1'b1; ovp_short_a = 1'b1; settle();
      ticks(TERM + 2);
      expect_out("R11 no short count on unselected ch1", 6'b01_1_0_1_1);
      led_hi_a[1] = 1'b0; ovp_short_a = 1'b0; settle();
      chsel_a = 1'b0; settle();
      expect_out("R11 ch1 back on when selected", ALL_ON);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule